// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Selectable Decay

This block produces the four gate commands of one full bridge: a high-side and a low-side switch on each of two legs, called leg A and leg B. A current-chopper upstream says whether the winding should be conducting or recirculating. A phase input gives the current direction, and a decay select chooses how the bridge recirculates during the off time. Two enables can force the bridge off: one per winding and one global.

Each leg is steered to one of three drive states: off, high side on, or low side on. Whenever a leg changes state, it passes through a guarded off interval of a parameterised number of clock cycles. Because of this, the multi-step recirculation patterns come out of the dead-time logic with no extra handling:
- Fast decay opens both conducting switches, then turns on one low side (quasi-synchronous rectification).
- Slow decay opens only the conducting low side, then closes the opposite high side (synchronous rectification).

Top module: `hbridge_gate_seq`

## Requirements
- R1: In neither leg are the high-side and low-side gates on in the same cycle.
- R2: A gate turns on only at the clock edge `DEAD_CYC` edges after the edge at which its leg was switched off or its leg's drive target last changed. Between those edges the leg stays fully off.
- R3: With both enables high and `conduct` high: `phase`=1 drives leg A high side and leg B low side, and `phase`=0 drives leg B high side and leg A low side.
- R4: With `slow_decay`=0 (fast decay), dropping `conduct` turns off both conducting switches at the next edge. After the dead time, only the low side of the leg whose high side was conducting turns on (leg A for `phase`=1, leg B for `phase`=0). Both high sides stay off.
- R5: With `slow_decay`=1 (slow decay), dropping `conduct` turns off only the conducting low side at the next edge, and the conducting high side stays on. After the dead time, the other leg's high side turns on, so both high sides are on.
- R6: When `conduct` returns high after either decay mode, the original diagonal pair is on again `DEAD_CYC` edges later.
- R7: `glb_en` low switches all four gates off at the next clock edge, and they stay off while it is low.
- R8: `wind_en` low switches all four gates off at the next clock edge, whatever `conduct` and `slow_decay` do.
- R9: A `phase` change during conduction turns all four gates off at the next edge. The new diagonal turns on `DEAD_CYC` edges later.
- R10: A change of drive target while a leg is still waiting off restarts that leg's dead-time count from the edge of the change.
- R11: While `rst_n` is low, all four gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable; low forces every gate off |
| wind_en | input | 1 | Winding enable; low forces every gate off |
| phase | input | 1 | Current direction: 1 = leg A high / leg B low |
| conduct | input | 1 | From the chopper: 1 = on time, 0 = recirculate |
| slow_decay | input | 1 | Decay select: 1 = slow, 0 = fast |
| gate_hs_a | output | 1 | Leg A high-side gate |
| gate_ls_a | output | 1 | Leg A low-side gate |
| gate_hs_b | output | 1 | Leg B high-side gate |
| gate_ls_b | output | 1 | Leg B low-side gate |

## Verification
Directed patterns cover each kind of transition:
- conduct to fast recirculation and back, which exercises a leg going high to off to low;
- conduct to slow recirculation and back, where one leg stays on throughout;
- a phase reversal, where both legs swap at once;
- a target change while a leg is still waiting off, which separates a count that restarts from one that keeps running.

The enable patterns toggle `conduct` while an enable is low, to show that the chop input has no effect then. A long pseudo-random run mixes all five inputs, including changes closer together than the dead time. On every cycle, that run is compared against a behavioural model of the four gates, which catches off-by-one errors in the dead-time edge.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_drive_t;

  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/hbg_target_decode.sv
module hbg_target_decode
  import hbg_pkg::*;
(
  input  logic       glb_en,
  input  logic       wind_en,
  input  logic       phase,
  input  logic       conduct,
  input  logic       slow_decay,
  output leg_drive_t tgt_a,
  output leg_drive_t tgt_b
);
  always_comb begin
    tgt_a = LEG_OFF;
    tgt_b = LEG_OFF;
    if (glb_en && wind_en) begin
      if (conduct) begin
        tgt_a = phase ? LEG_HI : LEG_LO;
        tgt_b = phase ? LEG_LO : LEG_HI;
      end else if (slow_decay) begin
        // recirculate through the upper half of the bridge
        tgt_a = LEG_HI;
        tgt_b = LEG_HI;
      end else begin
        // only the low side beside the freewheeling diode conducts
        tgt_a = phase ? LEG_LO  : LEG_OFF;
        tgt_b = phase ? LEG_OFF : LEG_LO;
      end
    end
  end
endmodule

// File: rtl/hbg_leg_seq.sv
module hbg_leg_seq
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  leg_drive_t tgt,
  output logic       gate_hi,
  output logic       gate_lo
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEAD_CYC);

  leg_drive_t    st_q, st_d;
  leg_drive_t    tgt_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tgt_moved;
  logic          dead_done;

  assign tgt_moved = (tgt != tgt_q);
  assign dead_done = (cnt_q >= CNT_LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    if (st_q != LEG_OFF && tgt != st_q) begin
      st_d  = LEG_OFF;
      cnt_d = '0;
    end else if (tgt_moved) begin
      cnt_d = '0;
    end else if (st_q == LEG_OFF && tgt != LEG_OFF && dead_done) begin
      st_d  = tgt;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LEG_OFF;
      tgt_q <= LEG_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt;
      cnt_q <= cnt_d;
    end
  end

  assign gate_hi = (st_q == LEG_HI);
  assign gate_lo = (st_q == LEG_LO);
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic glb_en,
  input  logic wind_en,
  input  logic phase,
  input  logic conduct,
  input  logic slow_decay,
  output logic gate_hs_a,
  output logic gate_ls_a,
  output logic gate_hs_b,
  output logic gate_ls_b
);
  leg_drive_t tgt [NUM_LEGS];
  logic       hi  [NUM_LEGS];
  logic       lo  [NUM_LEGS];

  hbg_target_decode u_dec (
    .glb_en     (glb_en),
    .wind_en    (wind_en),
    .phase      (phase),
    .conduct    (conduct),
    .slow_decay (slow_decay),
    .tgt_a      (tgt[0]),
    .tgt_b      (tgt[1])
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbg_leg_seq #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgt     (tgt[g]),
      .gate_hi (hi[g]),
      .gate_lo (lo[g])
    );
  end

  assign gate_hs_a = hi[0];
  assign gate_ls_a = lo[0];
  assign gate_hs_b = hi[1];
  assign gate_ls_b = lo[1];
endmodule

// File: rtl/hbg_gate_checker.sv
module hbg_gate_checker #(
  parameter int unsigned DEAD_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic glb_en,
  input logic wind_en,
  input logic slow_decay,
  input logic gate_hs_a,
  input logic gate_ls_a,
  input logic gate_hs_b,
  input logic gate_ls_b
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(DEAD_CYC);

  logic [CW-1:0] off_run_a, off_run_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run_a <= '0;
      off_run_b <= '0;
    end else begin
      if (gate_hs_a || gate_ls_a) off_run_a <= '0;
      else if (off_run_a != RUN_MAX) off_run_a <= off_run_a + 1'b1;
      if (gate_hs_b || gate_ls_b) off_run_b <= '0;
      else if (off_run_b != RUN_MAX) off_run_b <= off_run_b + 1'b1;
    end
  end

  assert_leg_a_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs_a && gate_ls_a));
  assert_leg_b_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs_b && gate_ls_b));

  assert_dead_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hs_a) || $rose(gate_ls_a)) |-> (off_run_a >= RUN_MAX));
  assert_dead_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hs_b) || $rose(gate_ls_b)) |-> (off_run_b >= RUN_MAX));

  assert_fast_no_dual_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_decay |=> !(gate_hs_a && gate_hs_b));

  assert_glb_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !(gate_hs_a || gate_ls_a || gate_hs_b || gate_ls_b));

  assert_wind_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wind_en |=> !(gate_hs_a || gate_ls_a || gate_hs_b || gate_ls_b));

  always_comb begin
    if (!rst_n) begin
      assert_reset_off_R11: assert (!(gate_hs_a || gate_ls_a || gate_hs_b || gate_ls_b));
    end
  end
endmodule

bind hbridge_gate_seq hbg_gate_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .glb_en     (glb_en),
  .wind_en    (wind_en),
  .slow_decay (slow_decay),
  .gate_hs_a  (gate_hs_a),
  .gate_ls_a  (gate_ls_a),
  .gate_hs_b  (gate_hs_b),
  .gate_ls_b  (gate_ls_b)
);

// File: tb/hbridge_gate_seq_test.sv
module hbridge_gate_seq_test;
  localparam int DEAD = 4;

  logic clk = 1'b0;
  logic rst_n, glb_en, wind_en, phase, conduct, slow_decay;
  logic gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  hbridge_gate_seq #(.DEAD_CYC(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .wind_en(wind_en),
    .phase(phase), .conduct(conduct), .slow_decay(slow_decay),
    .gate_hs_a(gate_hs_a), .gate_ls_a(gate_ls_a),
    .gate_hs_b(gate_hs_b), .gate_ls_b(gate_ls_b)
  );

  // Reference model: leg drive 0 = off, 1 = high side, 2 = low side
  int m_drv [2];
  int m_age [2];
  int m_want_prev [2];

  function automatic int want(int leg);
    if (!(glb_en && wind_en)) return 0;
    if (conduct) return (leg == 0) ? (phase ? 1 : 2) : (phase ? 2 : 1);
    if (slow_decay) return 1;
    if (leg == 0) return phase ? 2 : 0;
    return phase ? 0 : 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_drv[k] = 0; m_age[k] = 0; m_want_prev[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int w;
        w = want(k);
        if (m_drv[k] != 0 && w != m_drv[k]) begin
          m_drv[k] = 0; m_age[k] = 0;
        end else if (w != m_want_prev[k]) begin
          m_age[k] = 0;
        end else if (m_drv[k] == 0 && w != 0 && m_age[k] >= DEAD - 1) begin
          m_drv[k] = w; m_age[k] = 0;
        end else begin
          m_age[k] = m_age[k] + 1;
        end
        m_want_prev[k] = w;
      end
    end
  end

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: gates {hs_a,ls_a,hs_b,ls_b} got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] gates();
    return {gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b};
  endfunction

  function automatic logic [3:0] model_gates();
    return {m_drv[0] == 1, m_drv[0] == 2, m_drv[1] == 1, m_drv[1] == 2};
  endfunction

  // every-cycle comparison against the model, plus shoot-through check
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check("R2 model", gates(), model_gates());
      n_chk++;
      if ((gate_hs_a && gate_ls_a) || (gate_hs_b && gate_ls_b)) begin
        n_fail++;
        $display("FAIL R1: leg shoot-through, gates got %b expected no leg with both on", gates());
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a change at a negedge, check all-off for DEAD edges, then the pair.
  task automatic expect_after_dead(string tag, logic [3:0] first, logic [3:0] final_g);
    step(1);
    check(tag, gates(), first);
    step(DEAD - 1);
    check(tag, gates(), first);
    step(1);
    check(tag, gates(), final_g);
  endtask

  initial begin
    rst_n = 1'b0; glb_en = 1'b0; wind_en = 1'b0;
    phase = 1'b1; conduct = 1'b1; slow_decay = 1'b0;
    step(3);
    check("R11 reset", gates(), 4'b0000);
    rst_n = 1'b1;
    model_on = 1'b1;
    step(2);

    // R3: conduction diagonal for phase=1 after the initial dead time
    glb_en = 1'b1; wind_en = 1'b1;
    expect_after_dead("R3 phase1 conduct", 4'b0000, 4'b1001);

    // R4: fast decay, leg A low side only after dead time
    conduct = 1'b0;
    expect_after_dead("R4 fast decay", 4'b0000, 4'b0100);
    step(3);
    check("R4 fast decay hold", gates(), 4'b0100);

    // R6: back to conduction from fast decay
    conduct = 1'b1;
    expect_after_dead("R6 fast return", 4'b0000, 4'b1001);

    // R5: slow decay, leg A high stays on, leg B moves low -> high
    slow_decay = 1'b1; conduct = 1'b0;
    expect_after_dead("R5 slow decay", 4'b1000, 4'b1010);

    // R6: back to conduction from slow decay
    conduct = 1'b1;
    expect_after_dead("R6 slow return", 4'b1000, 4'b1001);

    // R9: phase reversal while conducting
    phase = 1'b0;
    expect_after_dead("R9 phase reversal", 4'b0000, 4'b0110);

    // R4 for phase=0: leg B low side only
    slow_decay = 1'b0; conduct = 1'b0;
    expect_after_dead("R4 fast decay phase0", 4'b0000, 4'b0001);
    conduct = 1'b1;
    expect_after_dead("R6 fast return phase0", 4'b0000, 4'b0110);

    // R8: winding enable low ignores chop toggles
    wind_en = 1'b0;
    step(1);
    check("R8 winding off", gates(), 4'b0000);
    for (int i = 0; i < 6; i++) begin
      conduct = ~conduct; slow_decay = i[0];
      step(1);
      check("R8 chop ignored", gates(), 4'b0000);
    end
    conduct = 1'b1; slow_decay = 1'b0;
    wind_en = 1'b1;
    expect_after_dead("R8 winding back", 4'b0000, 4'b0110);

    // R7: global enable low
    glb_en = 1'b0;
    step(1);
    check("R7 global off", gates(), 4'b0000);
    conduct = 1'b0;
    step(DEAD + 2);
    check("R7 global held off", gates(), 4'b0000);

    // R10: target change while waiting restarts the count
    conduct = 1'b1; phase = 1'b0;
    glb_en = 1'b1;
    step(2);
    check("R10 waiting", gates(), 4'b0000);
    phase = 1'b1;
    step(DEAD);
    check("R10 restarted count", gates(), 4'b0000);
    step(1);
    check("R10 on after restart", gates(), 4'b1001);

    // pseudo-random mix against the model
    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[2:0] == 3'd0) phase = ~phase;
        if (lfsr[5:3] < 3'd3) conduct = ~conduct;
        if (lfsr[9:6] == 4'd0) slow_decay = ~slow_decay;
        wind_en = (lfsr[15:11] != 5'd0);
        glb_en  = (lfsr[14:10] != 5'd31);
        step(1 + int'(lfsr[8:7]) * 2);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule